// File: doc/BRIEF.md
# Wide-to-Byte Bus Lane Bridge

This bridge connects a master with a 64-bit data path and eight byte-select bits to a slave whose data path is only one byte wide, such as a small peripheral register file with a 12-bit byte address. The narrow slave sees a byte address whose lowest three bits are derived from the active byte-select bit, not from the master's address. Write data is picked from the matching byte lane of the wide bus. Read data from the slave is returned in that same lane, and the other lanes read as zero.

Only single-byte accesses are forwarded. Any select pattern that does not have exactly one bit set is answered at once with an error response and never reaches the slave. The acknowledge from the slave can be passed straight through, or held for one clock in a register together with the read byte. The registered form is the default.

Top module: `wb_lane_bridge`

## Requirements
- R1: The slave's cycle and strobe follow the master's cycle and strobe only when exactly one bit of `m_sel` is set. Otherwise both stay low.
- R2: For a forwarded access, `s_adr[2:0]` is the index of the set bit of `m_sel`, with bit 0 mapping to 0 and bit 7 mapping to 7. `s_adr[11:3]` equals `m_adr`.
- R3: For a forwarded access, `s_dat_w` equals byte lane `m_dat_w[8*k+7:8*k]`, where k is the index of the set select bit.
- R4: Read data returned for a forwarded access occupies byte lane k of `m_dat_r`, and all other lanes are zero.
- R5: A strobed cycle with more than one select bit set raises `m_err` in the same cycle, keeps `m_ack` low and returns all ones on `m_dat_r`.
- R6: A strobed cycle with no select bit set is rejected in the same way as R5.
- R7: For a forwarded access, `s_we` equals `m_we`, and `m_err` stays low. With REG_ACK=1, `m_ack` is high exactly one clock after the slave acknowledges, and it carries the byte captured at that edge. With REG_ACK=0, `m_ack` equals `s_ack`.
- R8: While `rst` is high, `s_cyc`, `s_stb`, `m_ack` and `m_err` are low, whatever the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered acknowledge path |
| rst | input | 1 | Synchronous reset, active high |
| m_adr | input | 9 | Master address bits 11 down to 3 |
| m_dat_w | input | 64 | Master write data |
| m_sel | input | 8 | Master byte selects |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_dat_r | output | 64 | Read data returned to master |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Error response to master |
| s_adr | output | 12 | Slave byte address |
| s_dat_w | output | 8 | Slave write data |
| s_we | output | 1 | Slave write enable |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_dat_r | input | 8 | Slave read data |
| s_ack | input | 1 | Slave acknowledge |

## Verification
The hardest case to reach is a select pattern that differs from a one-hot value by a single extra bit, because an off-by-one or partial one-hot test would accept it. Purely random selects produce such patterns only rarely. The stimulus therefore draws most selects as one-hot values, some as a one-hot value with a second bit added, and some as fully random or all-zero values. It also sets every lane explicitly, including the patterns with bit 7 alone, all bits set and no bits set. Each access spans two clocks, so the bench sees both the same-cycle error response and the delayed acknowledge with its captured byte.

// File: rtl/wb_lane_bridge.sv
module wb_lane_bridge #(
  parameter int MDW     = 64,
  parameter int SAW     = 12,
  parameter bit REG_ACK = 1'b1,
  localparam int SELW = MDW / 8,
  localparam int LB   = $clog2(SELW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SAW-LB-1:0] m_adr,
  input  logic [MDW-1:0]    m_dat_w,
  input  logic [SELW-1:0]   m_sel,
  input  logic              m_cyc,
  input  logic              m_stb,
  input  logic              m_we,
  output logic [MDW-1:0]    m_dat_r,
  output logic              m_ack,
  output logic              m_err,
  output logic [SAW-1:0]    s_adr,
  output logic [7:0]        s_dat_w,
  output logic              s_we,
  output logic              s_cyc,
  output logic              s_stb,
  input  logic [7:0]        s_dat_r,
  input  logic              s_ack
);

  logic          ok;
  logic [LB-1:0] lane;
  logic [7:0]    rbyte;
  logic [MDW-1:0] placed;

  assign ok = (m_sel != '0) && ((m_sel & (m_sel - 1'b1)) == '0);

  always_comb begin
    lane = '0;
    for (int i = 0; i < SELW; i++)
      if (m_sel[i]) lane = lane | LB'(i);
  end

  assign s_adr   = {m_adr, lane};
  assign s_dat_w = m_dat_w[lane*8 +: 8];
  assign s_we    = m_we;
  assign s_cyc   = ok & m_cyc & ~rst;
  assign s_stb   = ok & m_stb & ~rst;
  assign m_err   = ~ok & m_cyc & m_stb & ~rst;

  for (genvar g = 0; g < SELW; g++) begin : g_lane
    assign placed[g*8 +: 8] = (lane == LB'(g)) ? rbyte : 8'h00;
  end

  assign m_dat_r = ok ? placed : '1;

  if (REG_ACK) begin : g_reg
    logic       ack_q;
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) ack_q <= 1'b0;
      else     ack_q <= s_cyc & s_stb & s_ack & ~ack_q;
      if (s_ack) byte_q <= s_dat_r;
    end
    assign m_ack = ack_q & ~rst;
    assign rbyte = byte_q;
  end else begin : g_comb
    assign m_ack = s_cyc & s_stb & s_ack;
    assign rbyte = s_dat_r;
  end

endmodule

// File: rtl/wb_lane_bridge_chk.sv
module wb_lane_bridge_chk #(
  parameter int MDW     = 64,
  parameter int SAW     = 12,
  parameter bit REG_ACK = 1'b1,
  localparam int SELW = MDW / 8,
  localparam int LB   = $clog2(SELW)
) (
  input logic              clk,
  input logic              rst,
  input logic [SELW-1:0]   m_sel,
  input logic              m_cyc,
  input logic              m_stb,
  input logic              m_ack,
  input logic              m_err,
  input logic [SAW-1:0]    s_adr,
  input logic              s_cyc,
  input logic              s_stb,
  input logic              s_ack
);

  p_fwd_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    (s_cyc || s_stb) |-> ($countones(m_sel) == 1 && m_cyc));

  p_lane_adr_r2: assert property (@(posedge clk) disable iff (rst)
    s_stb |-> m_sel[s_adr[LB-1:0]]);

  p_reject_r5: assert property (@(posedge clk) disable iff (rst)
    (m_cyc && m_stb && $countones(m_sel) != 1) |-> (m_err && !s_stb && !s_cyc));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(m_ack && m_err));

  if (REG_ACK) begin : g_ra
    p_ack_delay_r7: assert property (@(posedge clk) disable iff (rst)
      (s_cyc && s_stb && s_ack && !m_ack) |=> m_ack);
  end

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |-> (!s_cyc && !s_stb && !m_ack && !m_err));

endmodule

bind wb_lane_bridge wb_lane_bridge_chk #(.MDW(MDW), .SAW(SAW), .REG_ACK(REG_ACK)) u_chk (
  .clk(clk), .rst(rst), .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb),
  .m_ack(m_ack), .m_err(m_err), .s_adr(s_adr), .s_cyc(s_cyc),
  .s_stb(s_stb), .s_ack(s_ack)
);

// File: tb/sim_wb_lane_bridge.sv
`timescale 1ns/1ps
module sim_wb_lane_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  m_adr;
  logic [63:0] m_dat_w;
  logic [7:0]  m_sel;
  logic        m_cyc, m_stb, m_we;
  logic [63:0] m_dat_r;
  logic        m_ack, m_err;
  logic [11:0] s_adr;
  logic [7:0]  s_dat_w;
  logic        s_we, s_cyc, s_stb;
  logic [7:0]  s_dat_r;
  logic        s_ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wb_lane_bridge u0 (
    .clk(clk), .rst(rst), .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_dat_r(m_dat_r),
    .m_ack(m_ack), .m_err(m_err), .s_adr(s_adr), .s_dat_w(s_dat_w),
    .s_we(s_we), .s_cyc(s_cyc), .s_stb(s_stb), .s_dat_r(s_dat_r), .s_ack(s_ack)
  );

  function automatic bit one_hot(input logic [7:0] s);
    return $countones(s) == 1;
  endfunction

  function automatic int lane_of(input logic [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return i;
    return 0;
  endfunction

  function automatic logic [63:0] place(input logic [7:0] b, input int k);
    logic [63:0] r = '0;
    r[k*8 +: 8] = b;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    m_cyc = 0; m_stb = 0; m_we = 0; m_sel = '0; s_ack = 0;
  endtask

  task automatic access(input logic [8:0] a, input logic [63:0] d, input logic [7:0] s,
                        input logic we, input logic [7:0] rb);
    bit ok = one_hot(s);
    int k  = lane_of(s);
    @(negedge clk);
    m_adr = a; m_dat_w = d; m_sel = s; m_we = we; m_cyc = 1; m_stb = 1;
    s_dat_r = rb; s_ack = 1;
    #1;
    chk("R1 s_cyc", 64'(s_cyc), 64'(ok));
    chk("R1 s_stb", 64'(s_stb), 64'(ok));
    if (ok) begin
      chk("R2 s_adr", 64'(s_adr), 64'({a, 3'(k)}));
      chk("R3 s_dat_w", 64'(s_dat_w), 64'(d[k*8 +: 8]));
      chk("R7 s_we", 64'(s_we), 64'(we));
      chk("R7 m_err low", 64'(m_err), 64'd0);
    end else begin
      chk(s == 0 ? "R6 m_err" : "R5 m_err", 64'(m_err), 64'd1);
      chk(s == 0 ? "R6 data" : "R5 data", m_dat_r, '1);
    end
    chk("R7 no early ack", 64'(m_ack), 64'd0);
    @(posedge clk); #1;
    chk("R7 m_ack", 64'(m_ack), 64'(ok));
    if (ok) chk("R4 m_dat_r", m_dat_r, place(rb, k));
    else begin
      chk("R5 no ack", 64'(m_ack), 64'd0);
      chk("R5 data held", m_dat_r, '1);
    end
    @(negedge clk);
    idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst = 1; m_adr = 9'h1a5; m_dat_w = 64'h0123_4567_89ab_cdef; s_dat_r = 8'h5a;
    @(negedge clk);
    m_sel = 8'h04; m_cyc = 1; m_stb = 1; s_ack = 1;
    @(posedge clk); #1;
    chk("R8 s_cyc in reset", 64'(s_cyc), 64'd0);
    chk("R8 s_stb in reset", 64'(s_stb), 64'd0);
    chk("R8 m_ack in reset", 64'(m_ack), 64'd0);
    m_sel = 8'h06; #1;
    chk("R8 m_err in reset", 64'(m_err), 64'd0);
    @(negedge clk);
    idle(); rst = 0;
    @(posedge clk); #1;

    for (int k = 0; k < 8; k++)
      access(9'(k * 37), 64'hfedc_ba98_7654_3210, 8'(1 << k), k[0], 8'(8'h11 * k + 3));
    access(9'h000, 64'h0, 8'h00, 1'b0, 8'hff);
    access(9'h1ff, 64'h1, 8'hff, 1'b1, 8'h00);
    access(9'h0f0, 64'h2, 8'h81, 1'b0, 8'h7e);
    access(9'h1ff, {8{8'ha5}}, 8'h80, 1'b0, 8'hc3);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] s;
      int r = $urandom_range(0, 9);
      logic [7:0] oh = 8'(1 << $urandom_range(0, 7));
      if (r < 6) s = oh;
      else if (r < 8) s = oh | 8'(1 << $urandom_range(0, 7));
      else if (r == 8) s = 8'($urandom);
      else s = 8'h00;
      access(9'($urandom), {$urandom, $urandom}, s, 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule